// File: doc/BRIEF.md
# Microcontroller Low-Power Mode Controller

This block sits beside a small 8-bit processor core and decides which clocks run. Software writes a two-bit power-control register. One bit asks for a light sleep, in which only the CPU clock stops. The other bit asks for a deep sleep, in which the oscillator is turned off as well. The block gates the CPU clock, gates the peripheral clock, enables the oscillator and holds the core in reset. It also raises a RAM write-inhibit during the short stretch after a reset arrives in light sleep. It reports its state on a two-bit mode output.

There are two wake sources: the enabled interrupt requests and the external reset pin. An enabled interrupt ends light sleep at once and clears the light-sleep request bit. When reset arrives in light sleep, the core keeps running for two machine cycles with RAM writes blocked, and only then is it put into reset. Deep sleep ignores interrupts, and only the reset pin ends it. After any reset the core is held until the reset pin is low and the oscillator reports that it is stable. The power-control register returns to zero. The block never clears RAM.

The block's own state is cleared by a separate power-on reset, `rst_ni`. The reset pin is treated as a wake source and as a core reset request.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst_ni` is low, and afterwards until `rst_pin` is low and `osc_stable` is high, `core_rst` is 1, `mode` is 2'b11 and `pcon_q` is 0. In the cycle after both conditions hold, the block enters run: `mode` 2'b00, `core_rst` 0, and all three clock and oscillator enables at 1.
- R2: In run, a write (`pcon_wr`) with bit 0 set and bit 1 clear enters idle from the next cycle. In idle, `mode` is 2'b01, `cpu_clk_en` is 0, and `per_clk_en` and `osc_en` are 1.
- R3: In run, a write with bit 1 set enters power-down, even if bit 0 is also set. In power-down, `mode` is 2'b10 and `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R4: In idle, any bit of `irq_req & irq_en` returns the block to run in the next cycle and clears `pcon_q[0]`. Requests whose enable bit is 0 have no effect.
- R5: In power-down, interrupt requests are ignored, even when enabled. The mode stays 2'b10 and the oscillator stays off until `rst_pin` rises.
- R6: When `rst_pin` rises in power-down, the next cycle has `mode` 2'b11, `core_rst` 1 and `osc_en` 1. The core stays in reset until `osc_stable` is high and `rst_pin` is low.
- R7: When `rst_pin` rises in idle, the block opens a window of exactly 2×12 = 24 clocks. In this window `cpu_clk_en` is 1, `ram_wr_inhibit` is 1, `core_rst` is 0 and `mode` is 2'b11. After the window, `core_rst` is 1 and `ram_wr_inhibit` is 0.
- R8: Every path through core reset leaves `pcon_q` at 0 when run resumes.
- R9: Writes to the power-control register are ignored outside run. Both `pcon_q` and `mode` stay unchanged.
- R10: When `rst_pin` rises in run, the next cycle has `core_rst` 1 and `mode` 2'b11, with no write-inhibit window (`ram_wr_inhibit` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Power-on reset of the block, active low |
| rst_pin | input | 1 | External reset pin, active high |
| osc_stable | input | 1 | Oscillator has restarted and settled |
| pcon_wr | input | 1 | Write strobe for the power-control register |
| pcon_wdata | input | 2 | Write data: bit 0 idle request, bit 1 power-down request |
| irq_req | input | NIRQ | Interrupt requests |
| irq_en | input | NIRQ | Interrupt enables |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| core_rst | output | 1 | Holds the core and its registers in reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| mode | output | 2 | 00 run, 01 idle, 10 power-down, 11 reset-recovery |
| pcon_q | output | 2 | Current power-control register value |

## Verification
The hardest condition to reach is the reset that lands while the core is in idle. It needs a register write, a settled idle state with interrupts held quiet, and then the reset pin. The bench first reaches idle through a write, with every interrupt enable cleared. It then raises the reset pin and counts, one clock at a time, the cycles in which the CPU clock runs with RAM writes inhibited and the core out of reset. Deep sleep is probed with enabled interrupts held high for several cycles before reset is applied, so that a wrong wake would show on the mode output.

// File: rtl/lpm_ctrl.sv
module lpm_ctrl #(
  parameter int NIRQ    = 5,
  parameter int MC_CLKS = 12,
  parameter int WIN_MC  = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            rst_pin,
  input  logic            osc_stable,
  input  logic            pcon_wr,
  input  logic [1:0]      pcon_wdata,
  input  logic [NIRQ-1:0] irq_req,
  input  logic [NIRQ-1:0] irq_en,
  output logic            cpu_clk_en,
  output logic            per_clk_en,
  output logic            osc_en,
  output logic            core_rst,
  output logic            ram_wr_inhibit,
  output logic [1:0]      mode,
  output logic [1:0]      pcon_q
);
  localparam int WIN_CLKS = MC_CLKS * WIN_MC;
  localparam int CW       = $clog2(WIN_CLKS + 1);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_PD, S_WIN, S_RECOV} st_t;

  st_t           st, st_nx;
  logic [CW-1:0] win_cnt;
  logic          wake_irq, win_done;

  assign wake_irq = |(irq_req & irq_en);
  assign win_done = (win_cnt == CW'(WIN_CLKS - 1));

  always_comb begin
    st_nx = st;
    unique case (st)
      S_RUN: begin
        if (rst_pin)                     st_nx = S_RECOV;
        else if (pcon_wr && pcon_wdata[1]) st_nx = S_PD;
        else if (pcon_wr && pcon_wdata[0]) st_nx = S_IDLE;
      end
      S_IDLE: begin
        if (rst_pin)       st_nx = S_WIN;
        else if (wake_irq) st_nx = S_RUN;
      end
      S_PD:    if (rst_pin) st_nx = S_RECOV;
      S_WIN:   if (win_done) st_nx = S_RECOV;
      S_RECOV: if (!rst_pin && osc_stable) st_nx = S_RUN;
      default: st_nx = S_RECOV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st <= S_RECOV;
    else         st <= st_nx;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)          win_cnt <= '0;
    else if (st == S_WIN) win_cnt <= win_done ? '0 : win_cnt + 1'b1;
    else                  win_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                             pcon_q <= 2'b00;
    else if (st == S_RECOV)                  pcon_q <= 2'b00;
    else if (st == S_RUN && !rst_pin && pcon_wr) pcon_q <= pcon_wdata;
    else if (st == S_IDLE && !rst_pin && wake_irq) pcon_q[0] <= 1'b0;
  end

  assign cpu_clk_en     = (st == S_RUN) || (st == S_WIN) || (st == S_RECOV);
  assign per_clk_en     = (st != S_PD);
  assign osc_en         = (st != S_PD);
  assign core_rst       = (st == S_RECOV);
  assign ram_wr_inhibit = (st == S_WIN);

  always_comb begin
    unique case (st)
      S_RUN:   mode = 2'b00;
      S_IDLE:  mode = 2'b01;
      S_PD:    mode = 2'b10;
      default: mode = 2'b11;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int NIRQ    = 5,
  parameter int MC_CLKS = 12,
  parameter int WIN_MC  = 2
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            rst_pin,
  input logic            osc_stable,
  input logic            pcon_wr,
  input logic [1:0]      pcon_wdata,
  input logic [NIRQ-1:0] irq_req,
  input logic [NIRQ-1:0] irq_en,
  input logic            cpu_clk_en,
  input logic            per_clk_en,
  input logic            osc_en,
  input logic            core_rst,
  input logic            ram_wr_inhibit,
  input logic [1:0]      mode,
  input logic [1:0]      pcon_q
);
  localparam int WIN_CLKS = MC_CLKS * WIN_MC;
  localparam int CW       = $clog2(WIN_CLKS + 2);

  logic [CW-1:0] inh_run;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)             inh_run <= '0;
    else if (ram_wr_inhibit) inh_run <= inh_run + 1'b1;
    else                     inh_run <= '0;
  end

  // R1
  core_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(core_rst) |-> ($past(osc_stable) && !$past(rst_pin)));

  // R3
  pd_entry_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b00 && pcon_wr && pcon_wdata[1] && !rst_pin) |=> (mode == 2'b10 && !osc_en));

  // R3
  osc_off_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

  // R4
  idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b01 && |(irq_req & irq_en) && !rst_pin) |=> (mode == 2'b00 && !pcon_q[0]));

  // R5
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b10 && !rst_pin) |=> (mode == 2'b10));

  // R7
  inhibit_ctx_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    ram_wr_inhibit |-> (cpu_clk_en && !core_rst && mode == 2'b11));

  // R7
  inhibit_len_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    inh_run <= CW'(WIN_CLKS));

  // R9
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 2'b01 && pcon_wr && !rst_pin && !(|(irq_req & irq_en))) |=> $stable(pcon_q));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.NIRQ(NIRQ), .MC_CLKS(MC_CLKS), .WIN_MC(WIN_MC)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .osc_stable(osc_stable),
  .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .irq_req(irq_req), .irq_en(irq_en),
  .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
  .core_rst(core_rst), .ram_wr_inhibit(ram_wr_inhibit), .mode(mode), .pcon_q(pcon_q)
);

// File: tb/tb_lpm_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_ctrl;
  localparam int NIRQ = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, rst_pin = 1'b0, osc_stable = 1'b0, pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = 2'b00;
  logic [NIRQ-1:0] irq_req = '0, irq_en = '0;
  logic cpu_clk_en, per_clk_en, osc_en, core_rst, ram_wr_inhibit;
  logic [1:0] mode, pcon_q;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  lpm_ctrl #(.NIRQ(NIRQ)) dut (
    .clk(clk), .rst_ni(rst_ni), .rst_pin(rst_pin), .osc_stable(osc_stable),
    .pcon_wr(pcon_wr), .pcon_wdata(pcon_wdata), .irq_req(irq_req), .irq_en(irq_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .core_rst(core_rst), .ram_wr_inhibit(ram_wr_inhibit), .mode(mode), .pcon_q(pcon_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic outs(input string req, input int m, input int cpu, input int per,
                      input int osc, input int rst, input int inh);
    check(req, "mode", int'(mode), m);
    check(req, "cpu_clk_en", int'(cpu_clk_en), cpu);
    check(req, "per_clk_en", int'(per_clk_en), per);
    check(req, "osc_en", int'(osc_en), osc);
    check(req, "core_rst", int'(core_rst), rst);
    check(req, "ram_wr_inhibit", int'(ram_wr_inhibit), inh);
  endtask

  task automatic wr_pcon(input logic [1:0] d);
    pcon_wdata = d; pcon_wr = 1'b1;
    step();
    pcon_wr = 1'b0; pcon_wdata = 2'b00;
  endtask

  task automatic t_power_on;
    step(2);
    outs("R1", 3, 1, 1, 1, 1, 0);
    check("R1", "pcon_q in reset", int'(pcon_q), 0);
    rst_ni = 1'b1;
    step(4);
    check("R1", "held without osc_stable", int'(core_rst), 1);
    osc_stable = 1'b1;
    step();
    outs("R1", 0, 1, 1, 1, 0, 0);
  endtask

  task automatic t_idle_irq;
    irq_en = '0;
    wr_pcon(2'b01);
    outs("R2", 1, 0, 1, 1, 0, 0);
    check("R2", "pcon_q", int'(pcon_q), 1);
    irq_req = 5'b10110;
    step(3);
    check("R4", "disabled irqs keep idle", int'(mode), 1);
    irq_en = 5'b00100;
    step();
    irq_req = '0; irq_en = '0;
    check("R4", "mode after wake", int'(mode), 0);
    check("R4", "idle bit cleared", int'(pcon_q), 0);
    check("R4", "cpu clock back", int'(cpu_clk_en), 1);
  endtask

  task automatic t_idle_ignored_write;
    wr_pcon(2'b01);
    wr_pcon(2'b10);
    check("R9", "mode after write in idle", int'(mode), 1);
    check("R9", "pcon_q after write in idle", int'(pcon_q), 1);
    irq_req = 5'b00001; irq_en = 5'b00001;
    step();
    irq_req = '0; irq_en = '0;
    check("R4", "wake to run", int'(mode), 0);
  endtask

  task automatic t_pd_both;
    wr_pcon(2'b11);
    outs("R3", 2, 0, 0, 0, 0, 0);
    irq_req = '1; irq_en = '1;
    step(5);
    outs("R5", 2, 0, 0, 0, 0, 0);
    osc_stable = 1'b0;
    rst_pin = 1'b1;
    step();
    irq_req = '0; irq_en = '0;
    outs("R6", 3, 1, 1, 1, 1, 0);
    step(2);
    rst_pin = 1'b0;
    step(4);
    check("R6", "held until osc_stable", int'(core_rst), 1);
    osc_stable = 1'b1;
    step();
    outs("R6", 0, 1, 1, 1, 0, 0);
    check("R8", "pcon_q cleared after pd", int'(pcon_q), 0);
  endtask

  task automatic t_idle_reset;
    int win;
    wr_pcon(2'b01);
    check("R2", "in idle before reset", int'(mode), 1);
    rst_pin = 1'b1;
    step();
    win = 0;
    for (int i = 0; i < 40; i++) begin
      if (!(ram_wr_inhibit && cpu_clk_en && !core_rst && mode == 2'b11)) break;
      win++;
      step();
    end
    check("R7", "window length", win, 24);
    outs("R7", 3, 1, 1, 1, 1, 0);
    rst_pin = 1'b0;
    step();
    check("R8", "run after idle reset", int'(mode), 0);
    check("R8", "pcon_q cleared after idle reset", int'(pcon_q), 0);
  endtask

  task automatic t_run_reset;
    wr_pcon(2'b00);
    rst_pin = 1'b1;
    step();
    rst_pin = 1'b0;
    outs("R10", 3, 1, 1, 1, 1, 0);
    step();
    outs("R10", 0, 1, 1, 1, 0, 0);
  endtask

  initial begin
    fork
      begin
        t_power_on();
        t_idle_irq();
        t_idle_ignored_write();
        t_pd_both();
        t_idle_reset();
        t_run_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule